// File: doc/BRIEF.md
# UART Automatic RTS/CTS Handshake

This block performs hardware handshaking for a single UART channel. On the receive side it compares the receive FIFO fill count against a trigger level picked by a 2-bit code. It raises a level-sensitive interrupt request, and when automatic RTS is enabled it drives the active-low RTS# pin with hysteresis. RTS# deasserts at the trigger level one step above the selected one, and it reasserts only when the fill drops below the level one step beneath it.

On the transmit side, CTS# is synchronized through two flops. When automatic CTS is enabled, the synchronized value gates the transmitter's "start next character" request. The gating acts only at a character boundary, so a character that has already started is never cut short.

Software keeps authority over RTS#. When software does not assert RTS, the pin stays high whatever the FIFO level. When automatic RTS is off, the pin simply mirrors the software bit.

Top module: `uart_hwflow`

## Requirements
- R1: Out of reset the RTS hysteresis state is "asserted" and the synchronized CTS is "deasserted". With automatic CTS enabled, `tx_permit` stays 0 until a low CTS# has passed through the synchronizer.
- R2: `rx_trig_irq` is high exactly while `rx_count` is at or above the selected trigger level. The levels are 8, 16, 56 and 60 for `trig_sel` codes 0, 1, 2 and 3. The output follows `rx_count` with no clock delay.
- R3: With automatic RTS enabled and `sw_rts`=1, `rts_n` goes high on the clock edge at which `rx_count` is at or above the upper level. The upper levels are 16, 56, 60 and 64 for codes 0, 1, 2 and 3.
- R4: With automatic RTS enabled and `sw_rts`=1, `rts_n` returns low on the clock edge at which `rx_count` is below the lower level. The lower levels are 1, 8, 16 and 56 for codes 0, 1, 2 and 3. Between the lower and upper levels, `rts_n` holds its previous value.
- R5: While `sw_rts`=0, `rts_n` is 1 regardless of FIFO level or enables.
- R6: With automatic RTS disabled, `rts_n` equals the inverse of `sw_rts` with no clock delay.
- R7: With automatic CTS enabled, a change on `cts_n_pin` reaches `tx_permit` after two rising clock edges. A high CTS# blocks permission and a low CTS# allows it.
- R8: With automatic CTS disabled, `tx_permit` equals `tx_start_req`.
- R9: While automatic RTS is disabled, the hysteresis state is reloaded every cycle from the FIFO level: "asserted" if `rx_count` is below the upper level. On enable, `rts_n` therefore reflects the current level at once.
- R10: `tx_permit` is never 1 while `tx_start_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_rts_en | input | 1 | Enables automatic RTS control |
| auto_cts_en | input | 1 | Enables automatic CTS gating |
| rx_count | input | 7 | Receive FIFO fill count (0..64) |
| trig_sel | input | 2 | Receive trigger level code |
| sw_rts | input | 1 | Software RTS, 1 = assert |
| cts_n_pin | input | 1 | Asynchronous CTS# pin, active low |
| tx_start_req | input | 1 | Transmitter asks to start the next character |
| rts_n | output | 1 | RTS# pin, active low |
| tx_permit | output | 1 | Permission to start the requested character |
| rx_trig_irq | output | 1 | Receive trigger interrupt request, level |

## Verification
A corrupted hysteresis register shows at `rts_n` one clock edge after the FIFO count settles inside the band between the lower and upper levels. The bench therefore walks the count up and down one byte at a time through every code, so each possible flip point is observed within a single step. A wrong synchronizer stage or reset value shows at `tx_permit` within two edges of a CTS# change. A bad reload on enable shows on the first cycle after the enable rises.

// File: rtl/uart_hwflow.sv
module uart_hwflow #(
  parameter int DEPTH = 64,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 56,
  parameter int LVL3  = 60,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic [CW-1:0] rx_count,
  input  logic [1:0]    trig_sel,
  input  logic          sw_rts,
  input  logic          cts_n_pin,
  input  logic          tx_start_req,
  output logic          rts_n,
  output logic          tx_permit,
  output logic          rx_trig_irq
);

  logic [CW-1:0] trig_lvl, upper_lvl, lower_lvl;
  logic          rts_hold;
  logic          cts_s1, cts_s2;

  always_comb begin
    case (trig_sel)
      2'd0: begin trig_lvl = CW'(LVL0); upper_lvl = CW'(LVL1);  lower_lvl = CW'(1);    end
      2'd1: begin trig_lvl = CW'(LVL1); upper_lvl = CW'(LVL2);  lower_lvl = CW'(LVL0); end
      2'd2: begin trig_lvl = CW'(LVL2); upper_lvl = CW'(LVL3);  lower_lvl = CW'(LVL1); end
      default: begin trig_lvl = CW'(LVL3); upper_lvl = CW'(DEPTH); lower_lvl = CW'(LVL2); end
    endcase
  end

  assign rx_trig_irq = rx_count >= trig_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    rts_hold <= 1'b1;
    else if (!auto_rts_en)         rts_hold <= rx_count < upper_lvl;
    else if (rx_count >= upper_lvl) rts_hold <= 1'b0;
    else if (rx_count < lower_lvl) rts_hold <= 1'b1;
  end

  assign rts_n = !(sw_rts && (!auto_rts_en || rts_hold));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_s1 <= 1'b1;
      cts_s2 <= 1'b1;
    end else begin
      cts_s1 <= cts_n_pin;
      cts_s2 <= cts_s1;
    end
  end

  assign tx_permit = tx_start_req && (!auto_cts_en || !cts_s2);

  AST_RTS_SW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rts |-> rts_n); // R5

  AST_RTS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count >= upper_lvl) |=> !rts_hold); // R3

  AST_RTS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts_en && rx_count < lower_lvl) |=> rts_hold); // R4

  AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cts_n_pin) |=> !(auto_cts_en && tx_permit)); // R7

  AST_NO_REQ_NO_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_start_req |-> !tx_permit); // R10

endmodule

// File: tb/uart_hwflow_tb.sv
module uart_hwflow_tb;
  logic       clk = 0, rst_n = 0;
  logic       auto_rts_en = 0, auto_cts_en = 0;
  logic [6:0] rx_count = 0;
  logic [1:0] trig_sel = 0;
  logic       sw_rts = 0, cts_n_pin = 1, tx_start_req = 0;
  logic       rts_n, tx_permit, rx_trig_irq;
  int         checks = 0, fails = 0;
  logic       exp_hold;

  always #10 clk = ~clk;

  uart_hwflow u_dut (
    .clk(clk), .rst_n(rst_n), .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en),
    .rx_count(rx_count), .trig_sel(trig_sel), .sw_rts(sw_rts), .cts_n_pin(cts_n_pin),
    .tx_start_req(tx_start_req), .rts_n(rts_n), .tx_permit(tx_permit),
    .rx_trig_irq(rx_trig_irq)
  );

  function automatic int lvl(int s);
    return (s == 0) ? 8 : (s == 1) ? 16 : (s == 2) ? 56 : 60;
  endfunction
  function automatic int up_lvl(int s);  return (s == 3) ? 64 : lvl(s + 1); endfunction
  function automatic int lo_lvl(int s);  return (s == 0) ? 1  : lvl(s - 1); endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic step(int s, int c);
    @(negedge clk);
    rx_count = 7'(c);
    #1 chk("R2", rx_trig_irq, c >= lvl(s));
    @(posedge clk);
    if (c >= up_lvl(s))      exp_hold = 0;
    else if (c < lo_lvl(s))  exp_hold = 1;
    #1 chk(c >= up_lvl(s) ? "R3" : "R4", rts_n, !exp_hold);
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    sw_rts = 1; auto_rts_en = 1; auto_cts_en = 1; tx_start_req = 1;
    #35 rst_n = 1;
    #1 chk("R1", rts_n, 1'b0);
    chk("R1", tx_permit, 1'b0);
    cts_n_pin = 0;
    @(posedge clk); #1 chk("R1", tx_permit, 1'b0);
    @(posedge clk); #1 chk("R7", tx_permit, 1'b1);

    exp_hold = 1;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk) trig_sel = 2'(s);
      for (int c = 0; c <= 64; c++)  step(s, c);
      for (int c = 64; c >= 0; c--)  step(s, c);
    end

    @(negedge clk) sw_rts = 0;
    for (int c = 0; c <= 64; c += 8) begin
      @(negedge clk) rx_count = 7'(c);
      @(posedge clk); #1 chk("R5", rts_n, 1'b1);
    end

    @(negedge clk) auto_rts_en = 0; rx_count = 64; trig_sel = 0;
    for (int v = 0; v < 2; v++) begin
      @(negedge clk) sw_rts = v[0];
      #1 chk("R6", rts_n, !v[0]);
    end

    @(negedge clk) rx_count = 20;
    @(posedge clk);
    @(negedge clk) auto_rts_en = 1;
    #1 chk("R9", rts_n, 1'b1);
    @(negedge clk) auto_rts_en = 0; rx_count = 10;
    @(posedge clk);
    @(negedge clk) auto_rts_en = 1;
    #1 chk("R9", rts_n, 1'b0);
    @(negedge clk) rx_count = 12;
    @(posedge clk); #1 chk("R4", rts_n, 1'b0);

    @(negedge clk) cts_n_pin = 1;
    @(posedge clk); #1 chk("R7", tx_permit, 1'b1);
    @(posedge clk); #1 chk("R7", tx_permit, 1'b0);
    @(negedge clk) tx_start_req = 0;
    #1 chk("R10", tx_permit, 1'b0);
    @(negedge clk) auto_cts_en = 0;
    for (int v = 0; v < 2; v++) begin
      @(negedge clk) tx_start_req = v[0];
      #1 chk("R8", tx_permit, v[0]);
    end
    @(negedge clk) cts_n_pin = 0; tx_start_req = 0;
    @(posedge clk); @(posedge clk); #1 chk("R10", tx_permit, 1'b0);

    finish_run();
  end
endmodule